// File: doc/BRIEF.md
# Stopwatch Timer Interrupt Unit

This block produces the interrupt side of a stopwatch that counts in hundredths of a second. A small decimal count chain, advanced by a tick at twice the 100 Hz rate, generates three square waves at 100 Hz, 10 Hz and 1 Hz. Each wave has a 50 percent duty cycle. A falling-edge detector on each wave latches a per-source event flag. A combined, registered interrupt request is raised whenever a flag is set and its source is enabled.

Software sees two byte-wide registers on a simple bus with address, write strobe, write data and combinational read data. The enable register sits at `BASE_ADDR` and the flag register at `BASE_ADDR + 1`. Flags keep recording events while their source is masked. A flag is cleared by writing 1 to its bit.

Each falling-edge detector is a two-state machine:
- `LVL_HIGH` is the reset state. When the wave is seen low, it moves to `LVL_LOW` and emits a one-cycle fall event.
- `LVL_LOW` returns to `LVL_HIGH` when the wave is seen high again.

The count chain is built from three parts:
- a half-period phase bit;
- a hundredths BCD digit;
- a tenths BCD digit, which steps when the hundredths digit wraps from 9 to 0.

Top module: `swt_irq_unit`

## Requirements
- R1: After reset both registers read 0x00 and `irq` is 0.
- R2: The enable register at `BASE_ADDR` is read/write, with bit 0 = 100 Hz, bit 1 = 10 Hz and bit 2 = 1 Hz.
- R3: The flag register at `BASE_ADDR + 1` uses the same bit layout (bit 0 = 100 Hz, bit 1 = 10 Hz, bit 2 = 1 Hz). A flag is set by the falling edge of its wave.
- R4: Writing 1 to a flag bit clears that flag. Writing 0 to a flag bit leaves it unchanged.
- R5: Bits 7 to 3 of both registers always read 0, even after 0xFF is written.
- R6: A flag is recorded while its enable bit is 0, and a masked flag never raises `irq`.
- R7: `irq` is a register holding the OR over the sources of (flag AND enable). Enabling a source whose flag is already set raises `irq` on the second rising edge after the write. Clearing the flag drops `irq` in the same way.
- R8: When a falling edge and a write-1 clear hit the same flag in the same cycle, the flag ends up set.
- R9: Counting `n` ticks from reset, the 100 Hz wave falls on every odd `n`, the 10 Hz wave falls when `n mod 20 = 10`, and the 1 Hz wave falls when `n mod 200 = 100`. Both BCD digits stay in the range 0 to 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pulse at twice the 100 Hz rate |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| irq | output | 1 | Combined registered interrupt request |

## Verification
The hardest case to reach from the ports is a fall event and a write-1 clear landing on the same flag in the same clock cycle. The bench keeps its own count of ticks, so it knows which tick gives a 100 Hz fall. It then issues the clear write one cycle after that tick, which is exactly when the detector fires. The 1 Hz edge is also hard to reach, because it appears only at tick 100. The bench therefore pulses the tick every few clock cycles and checks all three flags after each of 200 consecutive ticks.

// File: rtl/swt_pkg.sv
package swt_pkg;
    localparam int NUM_SRC  = 3;
    localparam int DATA_W   = 8;
    localparam int DIG_W    = 4;
    localparam logic [DIG_W-1:0] DIG_MAX  = 4'd9;
    localparam logic [DIG_W-1:0] DIG_HALF = 4'd5;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_st_e;
endpackage

// File: rtl/swt_bcd_chain.sv
module swt_bcd_chain
    import swt_pkg::*;
#(
    parameter int N_DIG = NUM_SRC - 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    output logic [N_DIG:0] wave
);
    logic             phase_q;
    logic [N_DIG-1:0] step;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    phase_q <= 1'b0;
        else if (tick) phase_q <= ~phase_q;
    end

    assign step[0] = tick & phase_q;
    assign wave[0] = ~phase_q;

    for (genvar g = 0; g < N_DIG; g++) begin : g_dig
        logic [DIG_W-1:0] dig_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       dig_q <= '0;
            else if (step[g]) dig_q <= (dig_q == DIG_MAX) ? '0 : dig_q + 1'b1;
        end

        assign wave[g+1] = (dig_q < DIG_HALF);

        if (g < N_DIG - 1) begin : g_carry
            assign step[g+1] = step[g] && (dig_q == DIG_MAX);
        end

        p_digit_bcd_r9: assert property (@(posedge clk) disable iff (!rst_n)
            dig_q <= DIG_MAX)
            else $error("BCD digit out of range");
    end
endmodule

// File: rtl/swt_fall_fsm.sv
module swt_fall_fsm
    import swt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wave_in,
    output logic fall
);
    lvl_st_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LVL_HIGH: if (!wave_in) st_d = LVL_LOW;
            LVL_LOW:  if (wave_in)  st_d = LVL_HIGH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LVL_HIGH;
        else        st_q <= st_d;
    end

    always_comb begin
        fall = 1'b0;
        unique case (st_q)
            LVL_HIGH: fall = !wave_in;
            LVL_LOW:  fall = 1'b0;
        endcase
    end

    p_fall_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall)
        else $error("fall event lasted more than one cycle");
endmodule

// File: rtl/swt_irq_regs.sv
module swt_irq_regs
    import swt_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h22
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] fall,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               irq
);
    localparam logic [ADDR_W-1:0] EN_ADDR  = BASE_ADDR;
    localparam logic [ADDR_W-1:0] FLG_ADDR = BASE_ADDR + 1'b1;
    localparam int                PAD_W    = DATA_W - NUM_SRC;

    logic [NUM_SRC-1:0] en_q, flg_q, flg_d, clr;
    logic               wr_en, wr_flg, irq_q;
    logic               unused_wbits;

    assign unused_wbits = ^reg_wdata[DATA_W-1:NUM_SRC];
    assign wr_en  = reg_wr && (reg_addr == EN_ADDR);
    assign wr_flg = reg_wr && (reg_addr == FLG_ADDR);
    assign clr    = wr_flg ? reg_wdata[NUM_SRC-1:0] : '0;
    assign flg_d  = (flg_q & ~clr) | fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '0;
            flg_q <= '0;
            irq_q <= 1'b0;
        end else begin
            if (wr_en) en_q <= reg_wdata[NUM_SRC-1:0];
            flg_q <= flg_d;
            irq_q <= |(flg_q & en_q);
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == EN_ADDR)       reg_rdata = {{PAD_W{1'b0}}, en_q};
        else if (reg_addr == FLG_ADDR) reg_rdata = {{PAD_W{1'b0}}, flg_q};
    end

    assign irq = irq_q;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
        p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
            fall[i] |=> flg_q[i])
            else $error("fall event lost");
        p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_flg && reg_wdata[i] && !fall[i]) |=> !flg_q[i])
            else $error("write-1 did not clear flag");
        p_w0_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_flg && !reg_wdata[i] && flg_q[i]) |=> flg_q[i])
            else $error("write-0 disturbed flag");
    end

    p_en_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (en_q == $past(reg_wdata[NUM_SRC-1:0])))
        else $error("enable write lost");
    p_irq_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |=> !irq)
        else $error("irq raised with all sources masked");
endmodule

// File: rtl/swt_irq_unit.sv
module swt_irq_unit
    import swt_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    logic [NUM_SRC-1:0] wave;
    logic [NUM_SRC-1:0] fall;

    swt_bcd_chain #(.N_DIG(NUM_SRC - 1)) u_chain (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .wave  (wave)
    );

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        swt_fall_fsm u_fall (
            .clk     (clk),
            .rst_n   (rst_n),
            .wave_in (wave[s]),
            .fall    (fall[s])
        );
    end

    swt_irq_regs #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .fall      (fall),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );
endmodule

// File: tb/test_swt_irq_unit.sv
`timescale 1ns/1ps
module test_swt_irq_unit;
    localparam logic [7:0] EN_A  = 8'h22;
    localparam logic [7:0] FLG_A = 8'h23;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    int n_ticks = 0;

    always #10 clk = ~clk;

    swt_irq_unit #(.ADDR_W(8), .BASE_ADDR(8'h22)) i_swt_irq_unit (
        .clk(clk), .rst_n(rst_n), .tick(tick), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_fall(input int n);
        exp_fall = '0;
        exp_fall[0] = (n % 2) == 1;
        exp_fall[1] = (n % 20) == 10;
        exp_fall[2] = (n % 200) == 100;
    endfunction

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic step_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        @(negedge clk);
        n_ticks++;
    endtask

    task automatic make_even();
        if (n_ticks % 2 == 1) step_tick();
        do_write(FLG_A, 8'hFF);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        do_read(EN_A, d);  chk(d == 8'h00, "R1 enable reset", d, 0);
        do_read(FLG_A, d); chk(d == 8'h00, "R1 flag reset", d, 0);
        chk(irq == 1'b0, "R1 irq reset", irq, 0);
    endtask

    task automatic t_enable_rw();
        logic [7:0] d;
        do_write(EN_A, 8'hFF);
        do_read(EN_A, d); chk(d == 8'h07, "R5 enable reserved bits", d, 8'h07);
        do_write(EN_A, 8'h05);
        do_read(EN_A, d); chk(d == 8'h05, "R2 enable readback", d, 8'h05);
        do_write(EN_A, 8'h00);
        do_read(EN_A, d); chk(d == 8'h00, "R2 enable cleared", d, 0);
    endtask

    task automatic t_flag_w1c();
        logic [7:0] d;
        make_even();
        step_tick();
        do_read(FLG_A, d); chk(d == 8'h01, "R3 100Hz flag set", d, 1);
        chk(irq == 1'b0, "R6 masked flag no irq", irq, 0);
        do_write(FLG_A, 8'h00);
        do_read(FLG_A, d); chk(d == 8'h01, "R4 write 0 ignored", d, 1);
        do_write(FLG_A, 8'hFF);
        do_read(FLG_A, d); chk(d == 8'h00, "R4 R5 write 1 clears, reserved 0", d, 0);
    endtask

    task automatic t_irq_enable();
        logic [7:0] d;
        make_even();
        step_tick();
        do_write(EN_A, 8'h04);
        @(negedge clk); @(negedge clk);
        chk(irq == 1'b0, "R6 other source enabled only", irq, 0);
        do_write(EN_A, 8'h01);
        chk(irq == 1'b0, "R7 irq one cycle after enable", irq, 0);
        @(negedge clk);
        chk(irq == 1'b1, "R7 irq raised by enable", irq, 1);
        do_write(FLG_A, 8'h01);
        @(negedge clk);
        chk(irq == 1'b0, "R7 irq dropped after clear", irq, 0);
        do_read(FLG_A, d); chk(d == 8'h00, "R4 flag cleared", d, 0);
        do_write(EN_A, 8'h00);
    endtask

    task automatic t_set_wins();
        logic [7:0] d;
        make_even();
        @(negedge clk); tick = 1'b1; reg_addr = FLG_A;
        @(negedge clk); tick = 1'b0; reg_wdata = 8'h01; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
        n_ticks++;
        do_read(FLG_A, d); chk(d == 8'h01, "R8 set wins over clear", d, 1);
        do_write(FLG_A, 8'hFF);
    endtask

    task automatic t_rates();
        logic [7:0] d;
        int c0 = 0, c1 = 0, c2 = 0, mism = 0;
        do_write(FLG_A, 8'hFF);
        for (int k = 0; k < 200; k++) begin
            step_tick();
            do_read(FLG_A, d);
            if (d != exp_fall(n_ticks)) begin
                mism++;
                chk(1'b0, "R9 flag pattern", d, exp_fall(n_ticks));
            end
            c0 += d[0]; c1 += d[1]; c2 += d[2];
            do_write(FLG_A, 8'h07);
        end
        chk(mism == 0, "R9 no pattern mismatch", mism, 0);
        chk(c0 == 100, "R9 100Hz falls per 200 ticks", c0, 100);
        chk(c1 == 10,  "R9 10Hz falls per 200 ticks", c1, 10);
        chk(c2 == 1,   "R9 1Hz falls per 200 ticks", c2, 1);
    endtask

    initial begin
        #(20ns * 200000);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_enable_rw();
        t_flag_w1c();
        t_irq_enable();
        t_set_wins();
        t_rates();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule